// File: doc/BRIEF.md
# Dual-Mode Per-Processor Counter Timer

This block is a register-mapped timer placed once per processor. An external mode input picks one of two behaviours for the same counter. In limit mode the counter advances by one on each tick and, when it reaches a programmed 22-bit limit, returns to zero and raises a sticky interrupt. In user mode the counter widens to 54 bits, has a 54-bit limit written in two halves, and can be started and stopped by software.

All values on the bus are 32-bit words whose low nine bits stand for one counter unit of 512. A limit is therefore written into data bits 30:9, and the same bits are read back. The bus bridge in front of the block removes the byte offset and presents a two-bit word index. A register window of 16 bytes holds four words. Ticks come from an external prescaler and the interrupt goes to an external controller.

Top module: `cpu_timer`

## Requirements
- R1: The word index selects the register (0 limit/high, 1 low/count, 2 soft limit, 3 run control). Reads of words 2 and 3 return zero in both modes.
- R2: In limit mode, a write to word 0 loads the limit from data bits 30:9, clears the counter and clears the interrupt.
- R3: In limit mode, a write to word 2 loads the limit from data bits 30:9 and leaves the counter and the interrupt as they were.
- R4: In limit mode, a written limit of zero is stored as all ones, so word 0 then reads 0x7ffffe00.
- R5: In limit mode every tick adds one to the counter. A tick that would make the counter equal the limit sets it to zero and sets the interrupt, which stays set until a clearing event.
- R6: In user mode, a word 0 write loads limit bits 53:23 from data bits 30:0 and a word 1 write loads limit bits 22:0 from data bits 31:9. Each clears the counter and the interrupt. Word 2 writes are ignored.
- R7: In user mode, a write that would leave the whole 54-bit limit zero stores all ones instead.
- R8: A word 3 write in user mode sets the run flag from data bit 0, and ticks do not change a stopped counter. In limit mode a word 3 write has no effect.
- R9: Entering user mode clears the interrupt and counter, sets the limit to all ones and sets the run flag. Leaving user mode clears the counter and interrupt and keeps limit bits 21:0 as the limit-mode limit. A write in the cycle the mode changes is ignored.
- R10: In limit mode, word 0 reads the limit at bits 30:9 and word 1 reads the counter at bits 30:9. In user mode, word 0 reads counter bits 53:23 at bits 30:0 and word 1 reads counter bits 22:0 at bits 31:9.
- R11: A clearing write in the same cycle as a tick wins. A counter step always compares against the limit held before that cycle's write.
- R12: After reset the limit is all ones, the counter is zero, the interrupt is low and the run flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | 1 selects user mode, 0 selects limit mode |
| tick | input | 1 | One counter unit elapsed |
| addr | input | 2 | Register word index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from addr and state |
| irq | output | 1 | Sticky interrupt |

## Verification
Read data is combinational, so the bench samples it two nanoseconds before the edge, in the same cycle the word index is presented. Every register change, the interrupt included, becomes visible one nanosecond after the edge that accepts the write or tick. The interrupt is therefore checked one cycle after its cause. Same-cycle tick and write collisions and mode-change cycles get their own directed steps, because the outcome depends on which pre-edge limit and run values are used.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      WSEL_LIMIT = 2'd0,
      WSEL_LOWER = 2'd1,
      WSEL_SOFT  = 2'd2,
      WSEL_RUN   = 2'd3
   } wsel_e;

   typedef struct packed {
      logic proc_hard;
      logic proc_soft;
      logic usr_hi;
      logic usr_lo;
      logic run_wr;
   } wr_strobe_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
   import tmr_pkg::*;
(
   input  logic       user_mode,
   input  logic       mode_edge,
   input  logic       wr_en,
   input  logic [1:0] addr,
   output wr_strobe_t stb
);
   wsel_e sel;

   always_comb begin
      sel = wsel_e'(addr);
      stb = '0;
      if (wr_en && !mode_edge) begin
         unique case (sel)
            WSEL_LIMIT: begin
               if (user_mode) stb.usr_hi    = 1'b1;
               else           stb.proc_hard = 1'b1;
            end
            WSEL_LOWER: stb.usr_lo    = user_mode;
            WSEL_SOFT:  stb.proc_soft = ~user_mode;
            WSEL_RUN:   stb.run_wr    = user_mode;
         endcase
      end
   end
endmodule

// File: rtl/tmr_limit.sv
module tmr_limit
   import tmr_pkg::*;
#(
   parameter int PROC_W   = 22,
   parameter int CNT_W    = 54,
   parameter int DATA_W   = 32,
   parameter int SHIFT    = 9,
   parameter bit ZERO_SUB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              user_mode,
   input  wr_strobe_t        stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  limit,
   output logic              run,
   output logic              mode_edge,
   output logic              enter,
   output logic              clr
);
   localparam int LO_W = DATA_W - SHIFT;
   localparam int HI_W = CNT_W - LO_W;

   logic              mode_q;
   logic              leave;
   logic [PROC_W-1:0] proc_raw, proc_val;
   logic [CNT_W-1:0]  hi_raw, lo_raw, hi_val, lo_val;

   always_comb begin
      enter     = user_mode & ~mode_q;
      leave     = ~user_mode & mode_q;
      mode_edge = enter | leave;
      proc_raw  = wr_data[SHIFT +: PROC_W];
      hi_raw    = {wr_data[HI_W-1:0], limit[LO_W-1:0]};
      lo_raw    = {limit[CNT_W-1:LO_W], wr_data[DATA_W-1:SHIFT]};
      clr       = mode_edge | stb.proc_hard | stb.usr_hi | stb.usr_lo;
   end

   generate
      if (ZERO_SUB) begin : g_sub
         always_comb begin
            proc_val = (proc_raw == '0) ? '1 : proc_raw;
            hi_val   = (hi_raw   == '0) ? '1 : hi_raw;
            lo_val   = (lo_raw   == '0) ? '1 : lo_raw;
         end
         // R7
         limit_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (limit != '0));
      end else begin : g_raw
         always_comb begin
            proc_val = proc_raw;
            hi_val   = hi_raw;
            lo_val   = lo_raw;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         limit  <= '1;
         run    <= 1'b0;
      end else begin
         mode_q <= user_mode;
         if (enter) begin
            limit <= '1;
            run   <= 1'b1;
         end else begin
            if (stb.proc_hard || stb.proc_soft) limit[PROC_W-1:0] <= proc_val;
            else if (stb.usr_hi)                limit <= hi_val;
            else if (stb.usr_lo)                limit <= lo_val;
            if (stb.run_wr) run <= wr_data[0];
         end
      end
   end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int PROC_W = 22,
   parameter int CNT_W  = 54
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             user_mode,
   input  logic             tick,
   input  logic             run,
   input  logic             clr,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             irq
);
   logic [PROC_W-1:0] p_nxt;
   logic [CNT_W-1:0]  u_nxt;
   logic              hit;
   logic              step;

   always_comb begin
      p_nxt = cnt[PROC_W-1:0] + 1'b1;
      u_nxt = cnt + 1'b1;
      hit   = user_mode ? (u_nxt == limit) : (p_nxt == limit[PROC_W-1:0]);
      step  = tick & (run | ~user_mode);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         irq <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         irq <= 1'b0;
      end else if (step) begin
         if (hit) begin
            cnt <= '0;
            irq <= 1'b1;
         end else begin
            cnt <= user_mode ? u_nxt : CNT_W'(p_nxt);
         end
      end
   end

   // R8
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (user_mode && !run && !clr) |=> (cnt == $past(cnt)));

   // R5
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(tick));
endmodule

// File: rtl/cpu_timer.sv
module cpu_timer
   import tmr_pkg::*;
#(
   parameter int PROC_W   = 22,
   parameter int CNT_W    = 54,
   parameter int DATA_W   = 32,
   parameter int SHIFT    = 9,
   parameter int ADDR_W   = 2,
   parameter bit ZERO_SUB = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              user_mode,
   input  logic              tick,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int LO_W = DATA_W - SHIFT;
   localparam int HI_W = CNT_W - LO_W;

   generate
      if (ADDR_W != 2) begin : g_bad_addr
         $error("cpu_timer: ADDR_W must be 2");
      end
      if (PROC_W + SHIFT > DATA_W - 1) begin : g_bad_proc
         $error("cpu_timer: limit field does not fit below the top data bit");
      end
      if (HI_W < 1 || HI_W > DATA_W - 1) begin : g_bad_hi
         $error("cpu_timer: CNT_W does not split into two data words");
      end
      if (PROC_W > CNT_W) begin : g_bad_cnt
         $error("cpu_timer: PROC_W exceeds CNT_W");
      end
   endgenerate

   wr_strobe_t       stb;
   logic [CNT_W-1:0] limit, cnt;
   logic             run, mode_edge, enter, clr;

   tmr_decode u_dec (
      .user_mode (user_mode),
      .mode_edge (mode_edge),
      .wr_en     (wr_en),
      .addr      (addr),
      .stb       (stb)
   );

   tmr_limit #(
      .PROC_W(PROC_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
      .SHIFT(SHIFT), .ZERO_SUB(ZERO_SUB)
   ) u_lim (
      .clk       (clk),
      .rst_n     (rst_n),
      .user_mode (user_mode),
      .stb       (stb),
      .wr_data   (wr_data),
      .limit     (limit),
      .run       (run),
      .mode_edge (mode_edge),
      .enter     (enter),
      .clr       (clr)
   );

   tmr_count #(.PROC_W(PROC_W), .CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .user_mode (user_mode),
      .tick      (tick),
      .run       (run),
      .clr       (clr),
      .limit     (limit),
      .cnt       (cnt),
      .irq       (irq)
   );

   always_comb begin
      rd_data = '0;
      unique case (wsel_e'(addr))
         WSEL_LIMIT: rd_data = user_mode ? DATA_W'(cnt[CNT_W-1:LO_W])
                                         : DATA_W'(limit[PROC_W-1:0]) << SHIFT;
         WSEL_LOWER: rd_data = user_mode ? {cnt[LO_W-1:0], {SHIFT{1'b0}}}
                                         : DATA_W'(cnt[PROC_W-1:0]) << SHIFT;
         default:    rd_data = '0;
      endcase
   end

   // R2
   hard_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == WSEL_LIMIT && !user_mode && !mode_edge) |=> (!irq && cnt == '0));

   // R9
   enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter |=> (cnt == '0 && !irq && (&limit) && run));
endmodule

// File: tb/cpu_timer_bench.sv
module cpu_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        user_mode = 1'b0;
   logic        tick = 1'b0;
   logic [1:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq;

   always #10 clk = ~clk;

   cpu_timer u_cpu_timer (
      .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .tick(tick),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq(irq)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [53:0] m_lim = '1;
   logic [53:0] m_cnt = '0;
   logic        m_irq = 1'b0;
   logic        m_run = 1'b0;
   logic        m_mq  = 1'b0;

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic um, input logic [1:0] a);
      case (a)
         2'd0: return um ? {1'b0, m_cnt[53:23]} : {1'b0, m_lim[21:0], 9'b0};
         2'd1: return um ? {m_cnt[22:0], 9'b0} : {1'b0, m_cnt[21:0], 9'b0};
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_edge(input logic um, input logic we, input logic [1:0] a,
                             input logic [31:0] d, input logic tk);
      logic [53:0] ol = m_lim;
      logic        orun = m_run;
      logic        clr = 1'b0;
      logic [53:0] t;
      logic [21:0] n22;
      if (um && !m_mq) begin
         m_lim = '1; m_run = 1'b1; clr = 1'b1;
      end else if (!um && m_mq) begin
         clr = 1'b1;
      end else if (we) begin
         if (!um) begin
            if (a == 2'd0 || a == 2'd2)
               m_lim[21:0] = (d[30:9] == 0) ? 22'h3fffff : d[30:9];
            if (a == 2'd0) clr = 1'b1;
         end else begin
            if (a == 2'd0) begin
               t = {d[30:0], ol[22:0]}; m_lim = (t == 0) ? '1 : t; clr = 1'b1;
            end else if (a == 2'd1) begin
               t = {ol[53:23], d[31:9]}; m_lim = (t == 0) ? '1 : t; clr = 1'b1;
            end else if (a == 2'd3) begin
               m_run = d[0];
            end
         end
      end
      if (clr) begin
         m_cnt = '0; m_irq = 1'b0;
      end else if (tk && (!um || orun)) begin
         if (um) begin
            t = m_cnt + 1;
            if (t == ol) begin m_cnt = '0; m_irq = 1'b1; end
            else m_cnt = t;
         end else begin
            n22 = m_cnt[21:0] + 1;
            if (n22 == ol[21:0]) begin m_cnt = '0; m_irq = 1'b1; end
            else m_cnt = {32'h0, n22};
         end
      end
      m_mq = um;
   endtask

   task automatic step(input logic um, input logic we, input logic [1:0] a,
                       input logic [31:0] d, input logic tk, input string tag);
      @(negedge clk);
      user_mode = um; wr_en = we; addr = a; wr_data = d; tick = tk;
      #8;
      chk(rd_data, exp_rd(um, a), tag);
      @(posedge clk);
      model_edge(um, we, a, d, tk);
      #1;
      chk(irq, m_irq, tag);
   endtask

   task automatic peek(input logic um, input logic [1:0] a, input logic [31:0] exp,
                       input string tag);
      @(negedge clk);
      user_mode = um; wr_en = 1'b0; addr = a; wr_data = '0; tick = 1'b0;
      #8;
      chk(rd_data, exp, tag);
      @(posedge clk);
      model_edge(um, 1'b0, a, 32'h0, 1'b0);
      #1;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic um;
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R12 reset state
      peek(0, 2'd0, 32'h7ffffe00, "R12");
      peek(0, 2'd1, 32'h0, "R12");
      chk(irq, 0, "R12");
      // R2 hard load
      step(0, 1, 2'd0, 32'h600, 0, "R2");
      peek(0, 2'd0, 32'h600, "R2");
      // R5 counting to limit 3
      step(0, 0, 2'd1, 0, 1, "R5");
      step(0, 0, 2'd1, 0, 1, "R5");
      peek(0, 2'd1, 32'h400, "R10");
      chk(irq, 0, "R5");
      step(0, 0, 2'd1, 0, 1, "R5");
      chk(irq, 1, "R5");
      peek(0, 2'd1, 32'h0, "R5");
      repeat (3) step(0, 0, 2'd1, 0, 0, "R5");
      chk(irq, 1, "R5");
      // R8 run word ignored in limit mode
      step(0, 1, 2'd3, 32'h0, 0, "R8");
      step(0, 0, 2'd1, 0, 1, "R8");
      peek(0, 2'd1, 32'h200, "R8");
      // R3 soft load keeps count and interrupt
      step(0, 1, 2'd2, 32'h1000, 0, "R3");
      peek(0, 2'd1, 32'h200, "R3");
      peek(0, 2'd0, 32'h1000, "R3");
      chk(irq, 1, "R3");
      // R4 zero limit substitution
      step(0, 1, 2'd0, 32'h0, 0, "R4");
      peek(0, 2'd0, 32'h7ffffe00, "R4");
      chk(irq, 0, "R2");
      // R1 unmapped reads
      peek(0, 2'd2, 32'h0, "R1");
      peek(0, 2'd3, 32'h0, "R1");
      // R11 clearing write wins over tick
      step(0, 0, 2'd1, 0, 1, "R11");
      step(0, 1, 2'd0, 32'h400, 1, "R11");
      peek(0, 2'd1, 32'h0, "R11");
      // R9 enter user mode, write in edge cycle ignored
      step(1, 1, 2'd0, 32'h12345600, 0, "R9");
      peek(1, 2'd0, 32'h0, "R9");
      peek(1, 2'd1, 32'h0, "R9");
      chk(irq, 0, "R9");
      repeat (3) step(1, 0, 2'd1, 0, 1, "R9");
      peek(1, 2'd1, 32'h600, "R10");
      // R8 stop and start
      step(1, 1, 2'd3, 32'h0, 0, "R8");
      repeat (2) step(1, 0, 2'd1, 0, 1, "R8");
      peek(1, 2'd1, 32'h600, "R8");
      step(1, 1, 2'd3, 32'h1, 0, "R8");
      // R6 split limit = 5
      step(1, 1, 2'd0, 32'h0, 0, "R6");
      step(1, 1, 2'd1, 32'hA00, 0, "R6");
      peek(1, 2'd1, 32'h0, "R6");
      repeat (4) step(1, 0, 2'd1, 0, 1, "R6");
      chk(irq, 0, "R6");
      step(1, 0, 2'd1, 0, 1, "R6");
      chk(irq, 1, "R6");
      step(1, 1, 2'd1, 32'hA00, 0, "R6");
      step(1, 1, 2'd2, 32'h400, 0, "R6");
      repeat (2) step(1, 0, 2'd1, 0, 1, "R6");
      chk(irq, 0, "R6");
      repeat (3) step(1, 0, 2'd1, 0, 1, "R6");
      chk(irq, 1, "R6");
      // R7 whole-limit zero substitution, observed after leaving user mode
      step(1, 1, 2'd1, 32'h0, 0, "R7");
      step(1, 1, 2'd0, 32'h0, 0, "R7");
      step(0, 0, 2'd1, 0, 0, "R9");
      peek(0, 2'd0, 32'h7ffffe00, "R7");
      peek(0, 2'd1, 32'h0, "R9");

      // Random mix checked against the bench model
      um = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         logic        we, tk;
         logic [1:0]  a;
         logic [31:0] d;
         if ($urandom % 300 == 0) um = ~um;
         we = ($urandom % 4 == 0);
         a  = 2'($urandom % 4);
         d  = ($urandom % 5 == 0) ? $urandom
                                  : ((($urandom % 8) << 9) | ($urandom % 2));
         if (um && a == 2'd0 && ($urandom % 4 != 0)) d = 32'h0;
         tk = $urandom % 2;
         step(um, we, a, d, tk, "R5 R6 R10 R11 random");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule